// File: doc/BRIEF.md
# Masked Interrupt Request Aggregator

This block gathers seventeen level-sensitive device request lines into one processor interrupt. One of these lines is the cascade output of a legacy interrupt controller. The requests are split into three groups: sources 0 to 7, sources 8 to 15, and source 16 alone. Each group is reached through one byte-wide location on a small host register bus. A read returns the raw synchronized requests of that group. A write loads the group's mask in inverted form: a 1 in the written byte disables the source, and a 0 enables it.

The combined interrupt output is raised while any enabled source is pending. A hardware priority picker reports which source software should service next. The cascade line beats every other source. The remaining sources are taken lowest number first, and a group is searched only when all earlier groups have nothing enabled and pending. After reset only the cascade line is enabled.

Top module: `irqagg_top`

## Requirements
- R1: Address 0 reads the synchronized requests of sources 0-7, with source n on bit n. Address 1 reads sources 8-15, with source 8+n on bit n. Address 2 reads source 16 on bit 0 and zeros on bits 7:1. Address 3 reads zero.
- R2: A write to address 0 or 1 sets the enable of each source in that group to the inverse of the matching written bit. The new mask is in place after the clock edge that captures the write, and `irq_out`, `svc_valid` and `svc_idx` reflect it from that cycle on.
- R3: A write to address 2 enables source 16 when wdata bit 0 is 0 and disables it when that bit is 1. Written bits 7:1 have no effect.
- R4: After reset only the cascade source (source `CASCADE_BIT`, default 3) is enabled. All other sources are masked.
- R5: `irq_out` is 1 exactly when at least one source is both pending and enabled.
- R6: When the cascade source is pending and enabled, `svc_valid` is 1 and `svc_idx` equals `CASCADE_BIT`, whatever else is pending.
- R7: Otherwise `svc_idx` names the lowest-numbered pending enabled source in group 0. If group 0 has none, it names the lowest in group 1. If group 1 also has none, it names 16 when source 16 is pending and enabled.
- R8: When no enabled source is pending, `svc_valid` is 0 and `svc_idx` is 0.
- R9: Reads return requests regardless of the mask, so a masked pending source still reads as 1.
- R10: A change on `req` reaches reads and outputs after exactly two rising clock edges. It has not reached them after one.
- R11: A write to address 3 leaves every enable unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 17 | Level-sensitive request lines, source n on bit n |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 2 | Register select (0, 1, 2; 3 unused) |
| bus_wdata | input | 8 | Inverted mask byte to write |
| bus_rdata | output | 8 | Raw pending requests of the selected group |
| irq_out | output | 1 | Combined interrupt to the processor |
| svc_valid | output | 1 | A source is selected for service |
| svc_idx | output | 5 | Index 0-16 of the selected source |

## Verification
The bench builds the block with its defaults: the cascade on source 3 and a two-stage synchronizer. With the cascade on bit 3, the bench can place a lower-numbered group-0 source beside it, which shows that the cascade wins by precedence and not by position. Random request vectors mixed with random mask writes to all four addresses cover the ordering between groups, the single-bit group and the ignored address. Directed steps cover the reset mask and the two-edge request latency.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
    localparam int GRP_W   = 8;
    localparam int NUM_SRC = 2 * GRP_W + 1;
    localparam int IDX_W   = $clog2(NUM_SRC);
    localparam int LOW_W   = $clog2(GRP_W);

    typedef enum logic [1:0] {
        PICK_CASC = 2'd0,
        PICK_G0   = 2'd1,
        PICK_G1   = 2'd2,
        PICK_G2   = 2'd3
    } pick_grp_e;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } svc_pick_t;

    // Index of the lowest set bit in a group byte (0 when empty).
    function automatic logic [LOW_W-1:0] low_bit(input logic [GRP_W-1:0] v);
        logic [LOW_W-1:0] r;
        r = '0;
        for (int i = GRP_W - 1; i >= 0; i--) begin
            if (v[i]) r = LOW_W'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
    parameter int W      = 17,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= '0;
                    else     stg[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= '0;
                    else     stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/irqagg_mask_regs.sv
module irqagg_mask_regs
    import irqagg_pkg::*;
#(
    parameter int CASCADE_BIT = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [1:0]         addr,
    input  logic [GRP_W-1:0]   wdata,
    output logic [NUM_SRC-1:0] en
);
    localparam logic [GRP_W-1:0] G0_RST = GRP_W'(1) << CASCADE_BIT;

    logic [GRP_W-1:0] en_g0, en_g1;
    logic             en_g2;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_g0 <= G0_RST;
            en_g1 <= '0;
            en_g2 <= 1'b0;
        end else if (we) begin
            unique case (addr)
                2'd0:    en_g0 <= ~wdata;
                2'd1:    en_g1 <= ~wdata;
                2'd2:    en_g2 <= ~wdata[0];
                default: ;
            endcase
        end
    end

    assign en = {en_g2, en_g1, en_g0};
endmodule

// File: rtl/irqagg_prio_enc.sv
module irqagg_prio_enc
    import irqagg_pkg::*;
#(
    parameter int CASCADE_BIT = 3
) (
    input  logic [NUM_SRC-1:0] qual,
    output svc_pick_t          pick
);
    logic [GRP_W-1:0] q0, q1;
    logic             any;
    pick_grp_e        grp;

    assign q0  = qual[GRP_W-1:0];
    assign q1  = qual[2*GRP_W-1:GRP_W];
    assign any = |qual;

    always_comb begin
        if (q0[CASCADE_BIT])  grp = PICK_CASC;
        else if (|q0)         grp = PICK_G0;
        else if (|q1)         grp = PICK_G1;
        else                  grp = PICK_G2;
    end

    always_comb begin
        pick = '0;
        if (any) begin
            pick.valid = 1'b1;
            unique case (grp)
                PICK_CASC: pick.idx = IDX_W'(CASCADE_BIT);
                PICK_G0:   pick.idx = IDX_W'(low_bit(q0));
                PICK_G1:   pick.idx = IDX_W'(GRP_W) + IDX_W'(low_bit(q1));
                PICK_G2:   pick.idx = IDX_W'(2 * GRP_W);
                default:   pick.idx = '0;
            endcase
        end
    end
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
    import irqagg_pkg::*;
#(
    parameter int CASCADE_BIT = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [16:0]  req,
    input  logic         bus_we,
    input  logic [1:0]   bus_addr,
    input  logic [7:0]   bus_wdata,
    output logic [7:0]   bus_rdata,
    output logic         irq_out,
    output logic         svc_valid,
    output logic [4:0]   svc_idx
);
    logic [NUM_SRC-1:0] sync_req;
    logic [NUM_SRC-1:0] en_vec;
    logic [NUM_SRC-1:0] qual;
    svc_pick_t          pick;

    irqagg_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (req),
        .q   (sync_req)
    );

    irqagg_mask_regs #(.CASCADE_BIT(CASCADE_BIT)) u_mask (
        .clk   (clk),
        .rst   (rst),
        .we    (bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .en    (en_vec)
    );

    assign qual = sync_req & en_vec;

    irqagg_prio_enc #(.CASCADE_BIT(CASCADE_BIT)) u_enc (
        .qual (qual),
        .pick (pick)
    );

    always_comb begin
        unique case (bus_addr)
            2'd0:    bus_rdata = sync_req[GRP_W-1:0];
            2'd1:    bus_rdata = sync_req[2*GRP_W-1:GRP_W];
            2'd2:    bus_rdata = {{(GRP_W-1){1'b0}}, sync_req[2*GRP_W]};
            default: bus_rdata = '0;
        endcase
    end

    assign irq_out   = |qual;
    assign svc_valid = pick.valid;
    assign svc_idx   = pick.idx;
endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk #(
    parameter int CASCADE_BIT = 3
) (
    input logic        clk,
    input logic        rst,
    input logic [16:0] sync_req,
    input logic [16:0] en_vec,
    input logic        bus_we,
    input logic [1:0]  bus_addr,
    input logic [7:0]  bus_wdata,
    input logic        irq_out,
    input logic        svc_valid,
    input logic [4:0]  svc_idx
);
    logic [16:0] qual_c;
    assign qual_c = sync_req & en_vec;

    p_irq_valid_agree_r5: assert property (@(posedge clk) disable iff (rst)
        irq_out == svc_valid);

    p_cascade_first_r6: assert property (@(posedge clk) disable iff (rst)
        qual_c[CASCADE_BIT] |-> (svc_valid && svc_idx == 5'(CASCADE_BIT)));

    p_pick_enabled_r7: assert property (@(posedge clk) disable iff (rst)
        svc_valid |-> (svc_idx <= 5'd16 && qual_c[svc_idx]));

    p_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (qual_c == '0) |-> (!svc_valid && svc_idx == 5'd0));

    p_g1_write_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 2'd1) |=> (en_vec[15:8] == ~$past(bus_wdata)));

    p_g2_write_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 2'd2) |=> (en_vec[16] == ~$past(bus_wdata[0])));

    p_addr3_ignored_r11: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 2'd3) |=> $stable(en_vec));
endmodule

bind irqagg_top irqagg_chk #(.CASCADE_BIT(CASCADE_BIT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sync_req  (sync_req),
    .en_vec    (en_vec),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_out   (irq_out),
    .svc_valid (svc_valid),
    .svc_idx   (svc_idx)
);

// File: tb/tb_irqagg_top.sv
`timescale 1ns/1ps
module tb_irqagg_top;
    localparam int CASC = 3;

    logic        clk = 1'b0;
    logic        rst;
    logic [16:0] req;
    logic        bus_we;
    logic [1:0]  bus_addr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic        irq_out;
    logic        svc_valid;
    logic [4:0]  svc_idx;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [16:0] m_en;
    logic [16:0] m_req;

    always #4 clk = ~clk;

    irqagg_top #(.CASCADE_BIT(CASC), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .req(req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out),
        .svc_valid(svc_valid), .svc_idx(svc_idx)
    );

    // Expected pick: {valid, idx}
    function automatic logic [5:0] exp_pick(input logic [16:0] r, input logic [16:0] e);
        logic [16:0] q;
        q = r & e;
        if (q[CASC]) return {1'b1, 5'(CASC)};
        for (int i = 0; i < 17; i++) begin
            if (q[i]) return {1'b1, 5'(i)};
        end
        return 6'd0;
    endfunction

    function automatic logic [7:0] exp_read(input logic [1:0] a, input logic [16:0] r);
        case (a)
            2'd0:    return r[7:0];
            2'd1:    return r[15:8];
            2'd2:    return {7'd0, r[16]};
            default: return 8'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        logic [5:0] p;
        p = exp_pick(m_req, m_en);
        chk({tag, " R5 irq"},   {7'd0, irq_out},   {7'd0, |(m_req & m_en)});
        chk({tag, " R7 valid"}, {7'd0, svc_valid}, {7'd0, p[5]});
        chk({tag, " R7 idx"},   {3'd0, svc_idx},   {3'd0, p[4:0]});
        for (int a = 0; a < 4; a++) begin
            bus_addr = 2'(a);
            #1;
            chk({tag, " R1 read"}, bus_rdata, exp_read(2'(a), m_req));
        end
    endtask

    task automatic do_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        case (a)
            2'd0: m_en[7:0]  = ~d;
            2'd1: m_en[15:8] = ~d;
            2'd2: m_en[16]   = ~d[0];
            default: ;
        endcase
    endtask

    task automatic set_req(input logic [16:0] v);
        @(negedge clk);
        req = v;
        @(negedge clk);
        @(negedge clk);
        m_req = v;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        rst = 1'b1; req = '0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        m_en = 17'(1) << CASC; m_req = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R4: reset mask — all lines high, only cascade may be picked
        set_req(17'h1FFFF);
        chk("R4 reset pick", {3'd0, svc_idx}, 8'(CASC));
        check_all("R4");
        set_req(17'h00007);  // cascade low: sources 0-2 masked
        chk("R4 others masked", {7'd0, irq_out}, 8'd0);
        chk("R9 masked still read", bus_rdata, 8'd0); // addr 3 left selected
        bus_addr = 2'd0; #1;
        chk("R9 raw read", bus_rdata, 8'h07);
        check_all("R8");

        // R10: two-edge latency
        @(negedge clk); req = 17'h00008;
        @(negedge clk);
        chk("R10 one edge", {7'd0, irq_out}, 8'd0);
        @(negedge clk);
        chk("R10 two edges", {7'd0, irq_out}, 8'd1);
        m_req = 17'h00008;

        // R6: cascade beats lower source 1
        do_write(2'd0, 8'h00);
        set_req(17'h1000A);
        chk("R6 cascade first", {3'd0, svc_idx}, 8'(CASC));
        check_all("R6");

        // R2: mask change visible the cycle after the write
        do_write(2'd0, 8'hFF);
        do_write(2'd1, 8'hEF);
        set_req(17'h11010);
        chk("R2 g1 pick", {3'd0, svc_idx}, 8'd12);
        check_all("R2");

        // R3: source 16 via bit 0, upper bits ignored
        do_write(2'd1, 8'hFF);
        do_write(2'd2, 8'hFE);
        chk("R3 enable 16", {3'd0, svc_idx}, 8'd16);
        do_write(2'd2, 8'h01);
        chk("R3 disable 16", {7'd0, svc_valid}, 8'd0);
        check_all("R3");

        // R11: address 3 write has no effect
        do_write(2'd2, 8'h00);
        do_write(2'd3, 8'hFF);
        chk("R11 addr3 ignored", {3'd0, svc_idx}, 8'd16);
        check_all("R11");

        // Random mix
        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(0, 2) == 0)
                do_write(2'($urandom_range(0, 3)), 8'($urandom));
            set_req(17'($urandom) & (($urandom_range(0, 1) == 0) ? 17'h1FFFF : 17'h1FF00));
            check_all("rand");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule